// File: doc/BRIEF.md
# JTAG Boundary-Scan Test Access Unit

This block is a test access port for board-level and production test. A 16-state TAP controller advances on the rising edge of the test clock and follows the test-mode-select line. Serial data enters on the test data input. Data leaves on a test data output that changes on the falling edge and is enabled only while a register is being shifted. A 4-bit instruction register picks the data path placed between input and output. That path is a one-bit bypass stage, a 32-bit identification word, a one-bit system-reset hold register, or a boundary-scan chain built over a parameterised number of I/O pins.

Every pin contributes four boundary cells: pull-up disable, output enable, output value and sampled input. With the sample/preload instruction the chain captures the live pin state and fills the output latches, and the core keeps control of the pads. With the external-test instruction the latched values take over the pads once the new instruction is updated. The device has no dedicated high-impedance instruction. Instead, the reset instruction selects a one-bit register whose latched value holds the system in reset, and while that value is set the block also forces every pad's output enable low. The test interface is a plain serial protocol, so it has no valid/ready handshake and no back-pressure. The pin and control signals are plain levels.

Top module: `tap_scan_unit`

## Requirements
- R1: Five consecutive rising edges of `tck` with `tms` high reach Test-Logic-Reset from any state. Test-Logic-Reset and `trst_n` low both make IDCODE (opcode 0x1) the active instruction.
- R2: In Capture-IR the instruction shift register loads 4'b0001, so the first four bits out of an IR scan are 1,0,0,0.
- R3: Every register shifts least significant bit first. Under IDCODE, a 32-bit DR scan returns the parameter `ID_VALUE`, bit 0 first.
- R4: Opcode 0xF, and every opcode other than 0x0, 0x1, 0x2 and 0xC, selects a one-bit bypass stage that captures 0. A DR scan therefore returns 0 followed by the input bits delayed by one.
- R5: SAMPLE_PRELOAD (0x2) selects the boundary chain. For pin p, cell 4p captures `core_pud[p]`, cell 4p+1 captures `core_oe[p]`, cell 4p+2 captures `core_out[p]` and cell 4p+3 captures `pad_in[p]`. Update-DR loads the output latches while the pads keep following the core values.
- R6: EXTEST (0x0) selects the same chain with the same capture. The pads take the latched pull-up disable, output enable and output value from cells 4p, 4p+1 and 4p+2 immediately after Update-IR. Later Update-DR scans change the pads directly.
- R7: The reset instruction (0xC) selects a one-bit register that captures the current hold value. Update-DR copies the shifted bit to `sys_reset_hold`. While the hold is set and EXTEST is not active, every `pad_oe` bit is 0.
- R8: `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. `tdo` and `tdo_en` change only on the falling edge of `tck`, and `tdo` is 0 while disabled.
- R9: Entering Test-Logic-Reset clears `sys_reset_hold` and returns all pads to core control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| core_pud | input | NPINS | Core pull-up disable request per pin |
| core_oe | input | NPINS | Core output enable per pin |
| core_out | input | NPINS | Core output value per pin |
| pad_in | input | NPINS | Level seen at each pad |
| pad_pud | output | NPINS | Pull-up disable sent to each pad |
| pad_oe | output | NPINS | Output enable sent to each pad |
| pad_out | output | NPINS | Output value sent to each pad |
| sys_reset_hold | output | 1 | Holds the system in reset while high |

## Verification
A controller that has drifted into the wrong state shows up on the first scan. The captured IR pattern, the ID word or the bypass zero comes out misaligned or wrong on `tdo`, in the same shift cycles where the bench expects them. An instruction decoded wrongly changes which path is shifted. It can also change pad ownership in the cycle right after Update-IR, and the bench reads the pad outputs in that cycle. A hold or latch value that is lost or stale shows on `pad_oe`, `pad_out` or `sys_reset_hold` straight after the Update-DR edge, or after the fifth `tms`-high edge of a reset sequence.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    DR_BYP, DR_ID, DR_RST, DR_BSC
  } dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'h2;
  localparam logic [IR_W-1:0] OP_SYSRST = 4'hC;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;

  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state = state_q;

  // R1: five high TMS edges always end in Test-Logic-Reset
  p_five_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state_q == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_so,
  output dr_sel_e    dr_sel,
  output logic       extest_on
);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_act;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr  <= '0;
      ir_act <= OP_IDCODE;
    end else begin
      unique case (state)
        ST_CAP_IR: ir_sr  <= IR_CAPTURE_PAT;
        ST_SH_IR:  ir_sr  <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_act <= ir_sr;
        ST_TLR:    ir_act <= OP_IDCODE;
        default: ;
      endcase
    end
  end

  always_comb begin
    extest_on = 1'b0;
    unique case (ir_act)
      OP_EXTEST: begin dr_sel = DR_BSC; extest_on = 1'b1; end
      OP_IDCODE: dr_sel = DR_ID;
      OP_SAMPLE: dr_sel = DR_BSC;
      OP_SYSRST: dr_sel = DR_RST;
      default:   dr_sel = DR_BYP;
    endcase
  end

  assign ir_so = ir_sr[0];

  // R1: reset state of the controller restores IDCODE
  p_default_idcode_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> (ir_act == OP_IDCODE));

  // R2: capture pattern present at the start of Shift-IR
  p_capture_pattern_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE_PAT));

  // R6: the active instruction moves only at Update-IR or Test-Logic-Reset
  p_ir_holds_r6: assert property (@(posedge tck) disable iff (!trst_n)
    !(state == ST_UPD_IR || state == ST_TLR) |=> $stable(ir_act));

endmodule

// File: rtl/tap_small_dr.sv
`timescale 1ns/1ps
module tap_small_dr
  import tap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h25A3_C14B
)(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  dr_sel_e    dr_sel,
  output logic       byp_so,
  output logic       id_so,
  output logic       rst_so,
  output logic       rst_hold
);

  localparam int ID_W = $bits(ID_VALUE);

  logic            byp_q;
  logic [ID_W-1:0] id_sr;
  logic            rst_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q    <= 1'b0;
      id_sr    <= '0;
      rst_sr   <= 1'b0;
      rst_hold <= 1'b0;
    end else begin
      if (state == ST_TLR) rst_hold <= 1'b0;
      unique case (dr_sel)
        DR_BYP: begin
          if (state == ST_CAP_DR)     byp_q <= 1'b0;
          else if (state == ST_SH_DR) byp_q <= tdi;
        end
        DR_ID: begin
          if (state == ST_CAP_DR)     id_sr <= ID_VALUE;
          else if (state == ST_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
        DR_RST: begin
          if (state == ST_CAP_DR)      rst_sr   <= rst_hold;
          else if (state == ST_SH_DR)  rst_sr   <= tdi;
          else if (state == ST_UPD_DR) rst_hold <= rst_sr;
        end
        default: ;
      endcase
    end
  end

  assign byp_so = byp_q;
  assign id_so  = id_sr[0];
  assign rst_so = rst_sr;

  // R3: ID word loaded whole on capture, ready to leave LSB first
  p_id_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && dr_sel == DR_ID) |=> (id_sr == ID_VALUE));

  // R4: bypass stage starts every scan from 0
  p_bypass_zero_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && dr_sel == DR_BYP) |=> !byp_q);

  // R9: Test-Logic-Reset releases the system reset hold
  p_hold_release_r9: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> !rst_hold);

  // R7: the hold changes only at Update-DR under the reset instruction, or at reset
  p_hold_stable_r7: assert property (@(posedge tck) disable iff (!trst_n)
    !((state == ST_UPD_DR && dr_sel == DR_RST) || state == ST_TLR) |=> $stable(rst_hold));

endmodule

// File: rtl/tap_bscan_chain.sv
`timescale 1ns/1ps
module tap_bscan_chain
  import tap_pkg::*;
#(
  parameter int NPINS = 4
)(
  input  logic             tck,
  input  logic             trst_n,
  input  tap_state_e       state,
  input  logic             tdi,
  input  logic             sel,
  input  logic             extest_on,
  input  logic             rst_hold,
  input  logic [NPINS-1:0] core_pud,
  input  logic [NPINS-1:0] core_oe,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_pud,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic             chain_so
);

  localparam int CELLS = 4;
  localparam int CHAIN = CELLS * NPINS;

  logic [CHAIN-1:0] cap_vec;
  logic [CHAIN-1:0] chain_sr;
  logic [NPINS-1:0] lat_pud, lat_oe, lat_out;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      chain_sr <= '0;
    end else if (sel) begin
      if (state == ST_CAP_DR)     chain_sr <= cap_vec;
      else if (state == ST_SH_DR) chain_sr <= {tdi, chain_sr[CHAIN-1:1]};
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign cap_vec[CELLS*p + 0] = core_pud[p];
    assign cap_vec[CELLS*p + 1] = core_oe[p];
    assign cap_vec[CELLS*p + 2] = core_out[p];
    assign cap_vec[CELLS*p + 3] = pad_in[p];

    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
        lat_pud[p] <= 1'b0;
        lat_oe[p]  <= 1'b0;
        lat_out[p] <= 1'b0;
      end else if (sel && state == ST_UPD_DR) begin
        lat_pud[p] <= chain_sr[CELLS*p + 0];
        lat_oe[p]  <= chain_sr[CELLS*p + 1];
        lat_out[p] <= chain_sr[CELLS*p + 2];
      end
    end

    always_comb begin
      if (extest_on) begin
        pad_pud[p] = lat_pud[p];
        pad_oe[p]  = lat_oe[p];
        pad_out[p] = lat_out[p];
      end else begin
        pad_pud[p] = core_pud[p];
        pad_oe[p]  = rst_hold ? 1'b0 : core_oe[p];
        pad_out[p] = core_out[p];
      end
    end

    // R5: Update-DR copies the output cells of this pin into its latches
    p_latch_update_r5: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && state == ST_UPD_DR) |=>
        (lat_out[p] == $past(chain_sr[CELLS*p + 2])) &&
        (lat_oe[p]  == $past(chain_sr[CELLS*p + 1])));

    // R6: outside Update-DR the latches the pads may see do not move
    p_latch_hold_r6: assert property (@(posedge tck) disable iff (!trst_n)
      !(sel && state == ST_UPD_DR) |=> ($stable(lat_out[p]) && $stable(lat_oe[p])));
  end

  assign chain_so = chain_sr[0];

endmodule

// File: rtl/tap_scan_unit.sv
`timescale 1ns/1ps
module tap_scan_unit
  import tap_pkg::*;
#(
  parameter int          NPINS    = 4,
  parameter logic [31:0] ID_VALUE = 32'h25A3_C14B
)(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic [NPINS-1:0] core_pud,
  input  logic [NPINS-1:0] core_oe,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_pud,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic             sys_reset_hold
);

  tap_state_e state;
  dr_sel_e    dr_sel;
  logic       extest_on, ir_so;
  logic       byp_so, id_so, rst_so, chain_so;
  logic       dr_so;

  tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  tap_ir u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (state),
    .tdi       (tdi),
    .ir_so     (ir_so),
    .dr_sel    (dr_sel),
    .extest_on (extest_on)
  );

  tap_small_dr #(.ID_VALUE(ID_VALUE)) u_small (
    .tck      (tck),
    .trst_n   (trst_n),
    .state    (state),
    .tdi      (tdi),
    .dr_sel   (dr_sel),
    .byp_so   (byp_so),
    .id_so    (id_so),
    .rst_so   (rst_so),
    .rst_hold (sys_reset_hold)
  );

  tap_bscan_chain #(.NPINS(NPINS)) u_chain (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (state),
    .tdi       (tdi),
    .sel       (dr_sel == DR_BSC),
    .extest_on (extest_on),
    .rst_hold  (sys_reset_hold),
    .core_pud  (core_pud),
    .core_oe   (core_oe),
    .core_out  (core_out),
    .pad_in    (pad_in),
    .pad_pud   (pad_pud),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .chain_so  (chain_so)
  );

  always_comb begin
    unique case (dr_sel)
      DR_ID:   dr_so = id_so;
      DR_RST:  dr_so = rst_so;
      DR_BSC:  dr_so = chain_so;
      default: dr_so = byp_so;
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR)      tdo <= ir_so;
      else if (state == ST_SH_DR) tdo <= dr_so;
      else                        tdo <= 1'b0;
    end
  end

  // R8: output enable seen at a rising edge matches the shift state it followed
  p_tdo_window_r8: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == ((state == ST_SH_IR) || (state == ST_SH_DR)));

  // R8: a disabled output stays low
  p_tdo_quiet_r8: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);

endmodule

// File: tb/tap_scan_unit_test.sv
`timescale 1ns/1ps
module tap_scan_unit_test;

  localparam int          NP   = 4;
  localparam int          CH   = 4 * NP;
  localparam logic [31:0] IDV  = 32'h25A3_C14B;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic tdo, tdo_en, sys_reset_hold;
  logic [NP-1:0] core_pud, core_oe, core_out, pad_in;
  logic [NP-1:0] pad_pud, pad_oe, pad_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tap_scan_unit #(.NPINS(NP), .ID_VALUE(IDV)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en),
    .core_pud(core_pud), .core_oe(core_oe), .core_out(core_out), .pad_in(pad_in),
    .pad_pud(pad_pud), .pad_oe(pad_oe), .pad_out(pad_out),
    .sys_reset_hold(sys_reset_hold)
  );

  always #5 tck = ~tck;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CH-1:0] cap_model(input logic [NP-1:0] pu, oe, ov, pi);
    logic [CH-1:0] v;
    for (int p = 0; p < NP; p++) begin
      v[4*p] = pu[p]; v[4*p+1] = oe[p]; v[4*p+2] = ov[p]; v[4*p+3] = pi[p];
    end
    return v;
  endfunction

  function automatic logic [NP-1:0] field(input logic [CH-1:0] v, input int k);
    logic [NP-1:0] f;
    for (int p = 0; p < NP; p++) f[p] = v[4*p+k];
    return f;
  endfunction

  // one TCK cycle, starting just after a falling edge
  task automatic step(input logic m, input logic d, input bit shifting, output logic so);
    logic en;
    tms = m; tdi = d;
    #2;
    so = tdo; en = tdo_en;
    if (shifting) check(en === 1'b1, "R8 tdo_en high in shift", {31'b0, en}, 32'd1);
    @(posedge tck); #1;
    if (shifting) check(tdo === so, "R8 tdo steady after rising edge", {31'b0, tdo}, {31'b0, so});
    @(negedge tck); #1;
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
    logic s;
    step(1, 0, 0, s); step(1, 0, 0, s); step(0, 0, 0, s); step(0, 0, 0, s);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], 1, s); cap[i] = s;
    end
    step(1, 0, 0, s); step(0, 0, 0, s);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic s;
    dout = '0;
    step(1, 0, 0, s); step(0, 0, 0, s); step(0, 0, 0, s);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], 1, s); dout[i] = s;
    end
    step(1, 0, 0, s); step(0, 0, 0, s);
  endtask

  task automatic load_ir(input logic [3:0] op);
    logic [3:0] c;
    scan_ir(op, c);
    check(c == 4'b0001, "R2 IR capture pattern", {28'b0, c}, 32'h1);
  endtask

  task automatic tms_reset();
    logic s;
    for (int i = 0; i < 5; i++) step(1, 0, 0, s);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    logic [CH-1:0] pre, pre2;
    logic [3:0] op;
    logic s;
    void'($urandom(32'd4242));
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    core_pud = '0; core_oe = '0; core_out = '0; pad_in = '0;
    repeat (3) @(negedge tck);
    #1 trst_n = 1'b1;
    // reset state
    check(tdo_en === 1'b0, "R8 tdo_en low after reset", {31'b0, tdo_en}, 0);
    check(sys_reset_hold === 1'b0, "R9 hold low after reset", {31'b0, sys_reset_hold}, 0);
    core_out = 4'hA; core_oe = 4'h5; #1;
    check(pad_out == core_out && pad_oe == core_oe, "R9 pads follow core after reset",
          {24'b0, pad_out, pad_oe}, {24'b0, core_out, core_oe});
    step(0, 0, 0, s);
    check(tdo_en === 1'b0, "R8 tdo_en low in idle", {31'b0, tdo_en}, 0);

    // R1 / R3: default instruction reads the ID, LSB first
    scan_dr(32, 32'h0, got);
    check(got == IDV, "R1 R3 IDCODE after reset", got, IDV);

    // R1: random TMS wander, then five high edges
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 12; j++) step(1'($urandom), 1'($urandom), 0, s);
      tms_reset();
      step(0, 0, 0, s);
      scan_dr(32, $urandom, got);
      check(got == IDV, "R1 five TMS high restores IDCODE", got, IDV);
    end

    // R4: bypass for 0xF and for unassigned codes
    for (int k = 0; k < 8; k++) begin
      if (k == 0) op = 4'hF;
      else begin
        do op = 4'($urandom); while (op == 4'h0 || op == 4'h1 || op == 4'h2 || op == 4'hC);
      end
      load_ir(op);
      exp = $urandom & 32'hFF;
      scan_dr(8, exp, got);
      check(got[7:0] == {exp[6:0], 1'b0}, "R4 bypass one-bit delay", got, {24'b0, exp[6:0], 1'b0});
    end

    // R5 / R6: sample-preload then external test, random patterns
    for (int k = 0; k < 10; k++) begin
      core_pud = 4'($urandom); core_oe = 4'($urandom);
      core_out = 4'($urandom); pad_in = 4'($urandom);
      pre = 16'($urandom);
      load_ir(4'h2);
      scan_dr(CH, {16'b0, pre}, got);
      exp = {16'b0, cap_model(core_pud, core_oe, core_out, pad_in)};
      check(got == exp, "R5 sample capture cell order", got, exp);
      check(pad_out == core_out && pad_oe == core_oe && pad_pud == core_pud,
            "R5 pads untouched by preload", {20'b0, pad_pud, pad_oe, pad_out},
            {20'b0, core_pud, core_oe, core_out});
      load_ir(4'h0);
      check(pad_pud == field(pre, 0) && pad_oe == field(pre, 1) && pad_out == field(pre, 2),
            "R6 extest drives preload at Update-IR", {20'b0, pad_pud, pad_oe, pad_out},
            {20'b0, field(pre, 0), field(pre, 1), field(pre, 2)});
      pre2 = 16'($urandom);
      core_out = ~core_out; #1;
      scan_dr(CH, {16'b0, pre2}, got);
      exp = {16'b0, cap_model(core_pud, core_oe, core_out, pad_in)};
      check(got == exp, "R6 extest capture", got, exp);
      check(pad_out == field(pre2, 2) && pad_oe == field(pre2, 1),
            "R6 extest update drives pads", {24'b0, pad_oe, pad_out},
            {24'b0, field(pre2, 1), field(pre2, 2)});
    end

    // R9: TLR returns pads from extest to the core
    tms_reset(); step(0, 0, 0, s);
    check(pad_out == core_out && pad_pud == core_pud, "R9 TLR ends override",
          {24'b0, pad_pud, pad_out}, {24'b0, core_pud, core_out});

    // R7: reset hold register
    core_oe = 4'hF; #1;
    load_ir(4'hC);
    scan_dr(1, 32'h1, got);
    check(got[0] == 1'b0, "R7 hold capture before set", got, 0);
    check(sys_reset_hold === 1'b1, "R7 hold set by update", {31'b0, sys_reset_hold}, 1);
    check(pad_oe == '0, "R7 pads tri-stated while held", {28'b0, pad_oe}, 0);
    scan_dr(1, 32'h0, got);
    check(got[0] == 1'b1, "R7 hold captured back", got, 1);
    check(sys_reset_hold === 1'b0 && pad_oe == core_oe, "R7 hold released",
          {27'b0, sys_reset_hold, pad_oe}, {28'b0, core_oe});

    // R9: TLR clears a set hold
    scan_dr(1, 32'h1, got);
    check(sys_reset_hold === 1'b1, "R7 hold set again", {31'b0, sys_reset_hold}, 1);
    tms_reset();
    check(sys_reset_hold === 1'b0, "R9 TLR clears hold", {31'b0, sys_reset_hold}, 0);
    step(0, 0, 0, s);
    scan_dr(32, 32'h0, got);
    check(got == IDV, "R1 IDCODE after hold cleared", got, IDV);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule